// File: doc/BRIEF.md
# Dual-Host Primary Interrupt Aggregator

This block is the top stage of a two-stage interrupt controller. It gathers the request lines of up to eight secondary interrupt units. Each unit has one request line for each of two hosts. The block shows each host which units are asking for service. Each host side has its own status register and its own active-low interrupt output. A host side only ever sees that host's request lines. The secondary units do all per-source masking and edge detection, so this block does neither.

Software reaches the block through a byte-wide synchronous register port. It can read the two status registers. It can also read and write a test register, which forces status bits on both host sides at once; this is used to exercise the interrupt path. The parameter `IMPL_UNITS` sets how many unit slots are populated (default 6). Slots at or above that index are tied off.

Top module: `pri_irq_agg`

## Requirements
- R1: While `rst_n` is low, and after it is released with no requests, both outputs `irq_a_n` and `irq_b_n` are high, the test register is 0x00 and `rd_data` is 0x00.
- R2: Bit n of the line A status register (address 0x01) follows `req_a[n]`, and bit n of the line B status register (address 0x02) follows `req_b[n]`. A request change shows up in the status one clock edge after it is sampled.
- R3: A status bit clears by itself one edge after its request drops. Reading a status register never clears any bit.
- R4: `irq_a_n` is low exactly when some bit of line A status OR test bits is one. `irq_b_n` behaves the same way for line B. A request on one line never moves the other line's output.
- R5: A write to address 0x03 loads the test register. Its bits stay set until software writes zero to them. It reads back at 0x03. It is ORed into both status registers, so it drives both outputs.
- R6: Bit positions at or above `IMPL_UNITS` (bits 6 and 7 by default) always read zero at every address. Requests or test writes on those positions never assert an output.
- R7: Reads of addresses other than 0x01, 0x02 and 0x03 return 0x00. Writes to 0x01, 0x02 and to unmapped addresses change nothing.
- R8: A read (`bus_sel`=1, `bus_wr`=0) loads `rd_data` at the clock edge. `rd_data` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_a | input | 8 | Per-unit request lines for host A |
| req_b | input | 8 | Per-unit request lines for host B |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_a_n | output | 1 | Active-low interrupt to host A |
| irq_b_n | output | 1 | Active-low interrupt to host B |

## Verification
The hardest situation to reach is a status register that holds forced bits with no request behind them. The output must then stay asserted across reads and across writes to the read-only addresses. It must release only when the test register is written back to zero. The bench sets this up with all requests held low and a test-register write. It then mixes status reads, writes to 0x01, 0x02 and unmapped addresses, and a forced write to the tied-off bit positions. Only after that does it clear the test register. The vector table covers the live request patterns, including the tied-off slots and one-line-only traffic.

// File: rtl/pri_irq_agg.sv
module pri_irq_agg #(
  parameter int IMPL_UNITS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] req_a,
  input  logic [7:0] req_b,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] rd_data,
  output logic       irq_a_n,
  output logic       irq_b_n
);

  localparam int UNITS = 8;
  localparam logic [UNITS-1:0] IMPL_MASK = UNITS'((1 << IMPL_UNITS) - 1);
  localparam logic [7:0] ADR_STAT_A = 8'h01;
  localparam logic [7:0] ADR_STAT_B = 8'h02;
  localparam logic [7:0] ADR_FORCE  = 8'h03;

  logic [UNITS-1:0] stat_a, stat_b, force_q;
  logic [7:0]       rd_mux;

  wire rd_stb = bus_sel && !bus_wr;
  wire wr_force = bus_sel && bus_wr && (bus_addr == ADR_FORCE);
  wire [UNITS-1:0] view_a = stat_a | force_q;
  wire [UNITS-1:0] view_b = stat_b | force_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_a <= '0;
      stat_b <= '0;
    end else begin
      stat_a <= req_a & IMPL_MASK;
      stat_b <= req_b & IMPL_MASK;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        force_q <= '0;
    else if (wr_force) force_q <= bus_wdata & IMPL_MASK;

  always_comb
    case (bus_addr)
      ADR_STAT_A: rd_mux = view_a;
      ADR_STAT_B: rd_mux = view_b;
      ADR_FORCE:  rd_mux = force_q;
      default:    rd_mux = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rd_data <= 8'h00;
    else if (rd_stb) rd_data <= rd_mux;

  assign irq_a_n = ~|view_a;
  assign irq_b_n = ~|view_b;

  assert_req_a_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && |($past(req_a) & IMPL_MASK)) |-> !irq_a_n);

  assert_req_b_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && |($past(req_b) & IMPL_MASK)) |-> !irq_b_n);

  assert_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (($past(req_a) & IMPL_MASK) == 0) && force_q == 0) |-> irq_a_n);

  assert_force_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_force)) |-> $stable(force_q));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rd_stb)) |-> $stable(rd_data));

  assert_tied_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~IMPL_MASK) == 8'h00);

endmodule

// File: tb/pri_irq_agg_test.sv
`timescale 1ns/1ps
module pri_irq_agg_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_a = 8'h00, req_b = 8'h00;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] rd_data;
  logic       irq_a_n, irq_b_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pri_irq_agg #(.IMPL_UNITS(6)) uut (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data),
    .irq_a_n(irq_a_n), .irq_b_n(irq_b_n));

  // {req_a, req_b, read 0x01, read 0x02, irq_a_n, irq_b_n}
  localparam logic [33:0] VEC [8] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1},
    {8'h01, 8'h00, 8'h01, 8'h00, 1'b0, 1'b1},
    {8'h00, 8'h80, 8'h00, 8'h00, 1'b1, 1'b1},
    {8'h3F, 8'h00, 8'h3F, 8'h00, 1'b0, 1'b1},
    {8'hC0, 8'hC0, 8'h00, 8'h00, 1'b1, 1'b1},
    {8'h24, 8'h11, 8'h24, 8'h11, 1'b0, 1'b0},
    {8'hFF, 8'hFF, 8'h3F, 8'h3F, 1'b0, 1'b0},
    {8'h00, 8'h20, 8'h00, 8'h20, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic set_req(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    req_a = a;
    req_b = b;
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [7:0] adr, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = adr;
    @(posedge clk);
    #1;
    chk(req, $sformatf("read %02h", adr), rd_data, exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] adr, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = adr; bus_wdata = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic irqs(input string req, input logic ea, input logic eb);
    chk(req, "irq_a_n", {7'd0, irq_a_n}, {7'd0, ea});
    chk(req, "irq_b_n", {7'd0, irq_b_n}, {7'd0, eb});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    irqs("R1 in reset", 1'b1, 1'b1);
    chk("R1", "rd_data in reset", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    irqs("R1 after reset", 1'b1, 1'b1);
    rd(8'h03, 8'h00, "R1 test reg");

    for (int i = 0; i < 8; i++) begin
      set_req(VEC[i][33:26], VEC[i][25:18]);
      irqs($sformatf("R4 vec %0d", i), VEC[i][1], VEC[i][0]);
      rd(8'h01, VEC[i][17:10], $sformatf("R2 R6 vec %0d A", i));
      rd(8'h02, VEC[i][9:2],   $sformatf("R2 R6 vec %0d B", i));
    end

    // R3: reads do not clear; drop clears
    set_req(8'h08, 8'h00);
    rd(8'h01, 8'h08, "R3 first read");
    rd(8'h01, 8'h08, "R3 second read");
    irqs("R3 held", 1'b0, 1'b1);
    set_req(8'h00, 8'h00);
    irqs("R3 dropped", 1'b1, 1'b1);
    rd(8'h01, 8'h00, "R3 after drop");

    // R8: rd_data holds without a read
    rd(8'h03, 8'h00, "R8 prime");
    set_req(8'h02, 8'h02);
    repeat (2) @(posedge clk);
    #1;
    chk("R8", "rd_data hold", rd_data, 8'h00);
    set_req(8'h00, 8'h00);

    // R5: forced bits with no request
    wr(8'h03, 8'h05);
    irqs("R5 forced", 1'b0, 1'b0);
    rd(8'h03, 8'h05, "R5 readback");
    rd(8'h01, 8'h05, "R5 line A view");
    rd(8'h02, 8'h05, "R5 line B view");

    // R7: read-only and unmapped writes ignored
    wr(8'h01, 8'hFF);
    wr(8'h02, 8'hFF);
    wr(8'h09, 8'hFF);
    rd(8'h03, 8'h05, "R7 test reg kept");
    rd(8'h01, 8'h05, "R7 line A kept");
    rd(8'h02, 8'h05, "R7 line B kept");
    rd(8'h00, 8'h00, "R7 unmapped 00");
    rd(8'h07, 8'h00, "R7 unmapped 07");
    rd(8'hFF, 8'h00, "R7 unmapped FF");
    irqs("R5 still forced", 1'b0, 1'b0);

    // R6: tied-off positions in test reg
    wr(8'h03, 8'hC0);
    rd(8'h03, 8'h00, "R6 test high bits");
    irqs("R6 no irq", 1'b1, 1'b1);

    wr(8'h03, 8'h20);
    irqs("R5 set again", 1'b0, 1'b0);
    wr(8'h03, 8'h00);
    irqs("R5 cleared", 1'b1, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule